// File: doc/BRIEF.md
# Indirect Cartridge Control Register File

This block holds the write-only control state of a multi-game cartridge bank controller on an 8-bit CPU bus. The CPU reaches it through an index/value pair. A write into the page at $5000-$5FFF records which register the next value write goes to. A write anywhere in $8000-$FFFF then stores the data byte into that register. There are four registers. Two are game-level registers: a CHR bank and an inner PRG bank. Two are supervisor registers: a mode word and an outer PRG bank. The select word chooses between the two groups.

The block drives the CHR RAM upper address bits and the nametable A10 line itself. The banking fields are exported unchanged to the PRG address logic that sits outside. It also gates the PRG ROM chip enable, so the ROM drives the bus only on CPU reads of the upper half. Every register is sampled on one system clock. A write is qualified by a one-cycle bus strobe, and the stored value appears one cycle after the strobe.

Top module: `cart_ctl_regs`

## Requirements
- R1: Synchronous reset clears every register to zero, including the select word and the single-screen bit. Outputs then show bank 0, mode word 0 and one-screen lower mirroring.
- R2: A write (bus_cyc=1, bus_rw=0) to an address whose top nibble is 5 latches the select word. Data bit 7 chooses the group (0 game, 1 supervisor). Data bit 0 chooses the register inside the group. All other data bits are ignored.
- R3: A value write (bus_cyc=1, bus_rw=0, bus_addr[15]=1) with game register 0 selected stores data[1:0] into chr_hi.
- R4: A value write with game register 1 selected stores data[3:0] into inner_bank.
- R5: Every value write to a game register also stores data bit 4 into the single-screen bit. Value writes to supervisor registers leave that bit unchanged.
- R6: A value write with supervisor register 0 selected stores the mode word. Bits 5:4 go to outer_size, bits 3:2 to prg_mode and bits 1:0 to mirror_mode.
- R7: A value write with supervisor register 1 selected stores data[5:0] into outer_bank.
- R8: nt_a10 equals the single-screen bit when mirror_mode is 0 or 1. It equals ppu_a10 when mirror_mode is 2 and ppu_a11 when mirror_mode is 3.
- R9: rom_ce_n is low only while bus_cyc=1, bus_rw=1 and bus_addr[15]=1. It is high at all other times, including during register writes.
- R10: Reads, idle cycles (bus_cyc=0) and writes outside both windows leave every register unchanged. This includes the select word.
- R11: Each stored value appears on the outputs on the first clock edge after the write strobe and holds until the next write that targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | One-cycle bus-access strobe |
| bus_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| bus_addr | input | 16 | CPU address |
| bus_data | input | 8 | CPU write data |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| rom_ce_n | output | 1 | PRG ROM chip enable, active low |
| chr_hi | output | 2 | CHR RAM address bits 14:13 |
| nt_a10 | output | 1 | Nametable RAM A10 |
| inner_bank | output | 4 | Inner PRG bank field |
| outer_bank | output | 6 | Outer PRG bank field |
| outer_size | output | 2 | Outer bank size field |
| prg_mode | output | 2 | PRG bank mode field |
| mirror_mode | output | 2 | Mirroring mode field |

## Verification
Register contents are due exactly one clock edge after the strobe cycle. The bench drives each strobe on a falling edge and drops it on the next falling edge. It compares the outputs at that second falling edge, which lies after the single capturing rising edge. rom_ce_n and nt_a10 are combinational, so they are checked in the same half cycle in which their inputs change. The select word cannot be seen directly. Its effect, and the fact that ignored accesses did not disturb it, are read from which register the following value write lands in.

// File: rtl/cart_ctl_regs.sv
module cart_ctl_regs #(
  parameter logic [3:0] SEL_PAGE = 4'h5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_cyc,
  input  logic       bus_rw,
  input  logic [15:0] bus_addr,
  input  logic [7:0] bus_data,
  input  logic       ppu_a10,
  input  logic       ppu_a11,
  output logic       rom_ce_n,
  output logic [1:0] chr_hi,
  output logic       nt_a10,
  output logic [3:0] inner_bank,
  output logic [5:0] outer_bank,
  output logic [1:0] outer_size,
  output logic [1:0] prg_mode,
  output logic [1:0] mirror_mode
);

  logic sel_sup, sel_idx, one_scr;
  logic wr, wr_sel, wr_val;

  assign wr     = bus_cyc & ~bus_rw;
  assign wr_sel = wr & (bus_addr[15:12] == SEL_PAGE);
  assign wr_val = wr & bus_addr[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sup     <= 1'b0;
      sel_idx     <= 1'b0;
      one_scr     <= 1'b0;
      chr_hi      <= '0;
      inner_bank  <= '0;
      outer_bank  <= '0;
      outer_size  <= '0;
      prg_mode    <= '0;
      mirror_mode <= '0;
    end else begin
      if (wr_sel) begin
        sel_sup <= bus_data[7];
        sel_idx <= bus_data[0];
      end
      if (wr_val) begin
        if (!sel_sup) one_scr <= bus_data[4];
        unique case ({sel_sup, sel_idx})
          2'b00: chr_hi     <= bus_data[1:0];
          2'b01: inner_bank <= bus_data[3:0];
          2'b10: {outer_size, prg_mode, mirror_mode} <= bus_data[5:0];
          2'b11: outer_bank <= bus_data[5:0];
        endcase
      end
    end
  end

  always_comb begin
    unique case (mirror_mode)
      2'd2:    nt_a10 = ppu_a10;
      2'd3:    nt_a10 = ppu_a11;
      default: nt_a10 = one_scr;
    endcase
  end

  assign rom_ce_n = ~(bus_cyc & bus_rw & bus_addr[15]);

  AST_CE_IDLE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_rw |-> rom_ce_n); // R9
  AST_ONE_SCR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !mirror_mode[1] |-> nt_a10 == one_scr); // R8
  AST_SUP_KEEPS_M: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_sup) |=> $stable(one_scr)); // R5
  AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_val && sel_sup && sel_idx) |=> $stable(outer_bank)); // R7
  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (bus_rw || !bus_cyc) |=> $stable({sel_sup, sel_idx, one_scr, chr_hi, inner_bank,
                                      outer_bank, outer_size, prg_mode, mirror_mode})); // R10
  AST_CHR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_val && !sel_sup && !sel_idx) |=> $stable(chr_hi)); // R3

endmodule

// File: tb/test_cart_ctl_regs.sv
module test_cart_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic clk = 0, rst = 1, bus_cyc = 0, bus_rw = 1, ppu_a10 = 0, ppu_a11 = 1;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_data = '0;
  logic rom_ce_n, nt_a10;
  logic [1:0] chr_hi, outer_size, prg_mode, mirror_mode;
  logic [3:0] inner_bank;
  logic [5:0] outer_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_ctl_regs i_cart_ctl_regs (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_data(bus_data), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .rom_ce_n(rom_ce_n),
    .chr_hi(chr_hi), .nt_a10(nt_a10), .inner_bank(inner_bank), .outer_bank(outer_bank),
    .outer_size(outer_size), .prg_mode(prg_mode), .mirror_mode(mirror_mode));

  // {addr, data, rw, chr, inner, mode word, outer, nt_a10} with ppu_a10=0, ppu_a11=1
  localparam logic [43:0] VEC [NV] = '{
    {16'h5000, 8'h00, 1'b0, 2'd0, 4'h0, 6'h00, 6'h00, 1'b0},  // R2 select game 0
    {16'h8000, 8'h13, 1'b0, 2'd3, 4'h0, 6'h00, 6'h00, 1'b1},  // R3 R5
    {16'h5123, 8'h01, 1'b0, 2'd3, 4'h0, 6'h00, 6'h00, 1'b1},  // R2 select game 1
    {16'hC000, 8'h0A, 1'b0, 2'd3, 4'hA, 6'h00, 6'h00, 1'b0},  // R4 R5
    {16'hFFFF, 8'h1F, 1'b0, 2'd3, 4'hF, 6'h00, 6'h00, 1'b1},  // R4 R5
    {16'h5FFF, 8'h80, 1'b0, 2'd3, 4'hF, 6'h00, 6'h00, 1'b1},  // R2 select sup 0
    {16'h8000, 8'h3D, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h00, 1'b1},  // R6, M kept R5
    {16'h5000, 8'h81, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h00, 1'b1},  // R2 select sup 1
    {16'h9000, 8'hEA, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h2A, 1'b1},  // R7
    {16'h8000, 8'h00, 1'b1, 2'd3, 4'hF, 6'h3D, 6'h2A, 1'b1},  // R10 read
    {16'h4000, 8'h00, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h2A, 1'b1},  // R10 outside
    {16'h7FFF, 8'h80, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h2A, 1'b1},  // R10 outside
    {16'h8000, 8'h15, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h15, 1'b1},  // R7 select kept
    {16'h5000, 8'h80, 1'b0, 2'd3, 4'hF, 6'h3D, 6'h15, 1'b1},  // R2
    {16'h8000, 8'h02, 1'b0, 2'd3, 4'hF, 6'h02, 6'h15, 1'b0},  // R8 vertical
    {16'h8000, 8'h03, 1'b0, 2'd3, 4'hF, 6'h03, 6'h15, 1'b1},  // R8 horizontal
    {16'h5000, 8'h00, 1'b0, 2'd3, 4'hF, 6'h03, 6'h15, 1'b1},  // R2
    {16'h8000, 8'h02, 1'b0, 2'd2, 4'hF, 6'h03, 6'h15, 1'b1},  // R3 R5
    {16'h5000, 8'hFE, 1'b0, 2'd2, 4'hF, 6'h03, 6'h15, 1'b1},  // R2 bits 7,0 only
    {16'h5000, 8'h01, 1'b1, 2'd2, 4'hF, 6'h03, 6'h15, 1'b1},  // R10 read of select page
    {16'h8000, 8'h00, 1'b0, 2'd2, 4'hF, 6'h00, 6'h15, 1'b0}   // R6 R8 R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] state();
    return {chr_hi, inner_bank, outer_size, prg_mode, mirror_mode, outer_bank, nt_a10};
  endfunction

  task automatic access(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic cyc = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rw = rw; bus_cyc = cyc;
    @(negedge clk);
    bus_cyc = 0; bus_rw = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset state", {13'd0, state()}, 32'd0);
    check("R9 idle ce", {31'd0, rom_ce_n}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][43:28], VEC[i][27:20], VEC[i][19]);
      check($sformatf("R11 vector %0d", i), {13'd0, state()}, {13'd0, VEC[i][18:0]});
    end

    // R10: write strobe absent
    access(16'h8000, 8'h3F, 1'b0, 1'b0);
    check("R10 no strobe", {26'd0, outer_size, prg_mode, mirror_mode}, 32'h00);

    // R5 R8: one-screen modes follow M
    access(16'h8000, 8'h01, 1'b0);
    check("R8 one-screen upper M=0", {31'd0, nt_a10}, 32'd0);
    access(16'h5000, 8'h00, 1'b0);
    access(16'h8000, 8'h10, 1'b0);
    check("R5 M set", {31'd0, nt_a10}, 32'd1);
    check("R3 chr cleared", {30'd0, chr_hi}, 32'd0);

    // R8: vertical and horizontal follow PPU lines
    access(16'h5000, 8'h80, 1'b0);
    access(16'h8000, 8'h02, 1'b0);
    ppu_a10 = 1; ppu_a11 = 0; #1;
    check("R8 vertical a10=1", {31'd0, nt_a10}, 32'd1);
    ppu_a10 = 0; ppu_a11 = 1; #1;
    check("R8 vertical a10=0", {31'd0, nt_a10}, 32'd0);
    access(16'h8000, 8'h03, 1'b0);
    ppu_a11 = 0; #1;
    check("R8 horizontal a11=0", {31'd0, nt_a10}, 32'd0);
    ppu_a11 = 1; #1;
    check("R8 horizontal a11=1", {31'd0, nt_a10}, 32'd1);

    // R9: chip enable gating
    @(negedge clk);
    bus_cyc = 1; bus_rw = 1; bus_addr = 16'h8000; #1;
    check("R9 read upper", {31'd0, rom_ce_n}, 32'd0);
    bus_rw = 0; bus_data = 8'h00; bus_addr = 16'h7FFF; #1;
    check("R9 write low", {31'd0, rom_ce_n}, 32'd1);
    bus_rw = 1; #1;
    check("R9 read below", {31'd0, rom_ce_n}, 32'd1);
    bus_cyc = 0; bus_addr = 16'hC000; #1;
    check("R9 no cycle", {31'd0, rom_ce_n}, 32'd1);
    @(negedge clk);
    bus_cyc = 1; bus_rw = 0; bus_addr = 16'hC000; #1;
    check("R9 write upper", {31'd0, rom_ce_n}, 32'd1);
    @(negedge clk);
    bus_cyc = 0; bus_rw = 1;

    // R1: reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset clears", {13'd0, state()}, 32'd0);
    access(16'h8000, 8'h03, 1'b0);
    check("R1 select cleared", {30'd0, chr_hi}, 32'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule